// File: doc/BRIEF.md
# Banked Nibble Store with Output Port Latches

This block keeps the 4-bit storage that a small processor reaches through a previously loaded 8-bit select value and a current bank number. It contains the main data characters, a smaller set of status characters per register, one output latch per RAM chip and one latch per ROM chip. Each cycle the surrounding datapath presents a command, the select value, the bank number, a status-character index and an accumulator nibble. The block answers with a 4-bit read value.

The same select value is cut into different fields depending on the command. Character accesses use the whole value together with the bank. Status accesses use the upper nibble together with the separate status index. RAM port writes combine the top two select bits with the bank. ROM port accesses use only the upper nibble. Writes land on the rising clock edge. Reads are combinational from the stored state. Reset clears the port latches and leaves memory contents alone.

Top module: `banked_store`

## Requirements
- R1: A character write (`cmd_op`=1) stores `acc_in` at the location given by `bank_sel`, chip `sel_addr[7:6]`, register `sel_addr[5:4]` and character `sel_addr[3:0]` on the clock edge. A character read (`cmd_op`=2) returns that nibble combinationally. Locations that differ only in `bank_sel` are distinct.
- R2: A status write (`cmd_op`=3) stores `acc_in` at the location given by `bank_sel`, `sel_addr[7:4]` and `stat_idx`. A status read (`cmd_op`=4) returns it. `sel_addr[3:0]` has no effect on status accesses, and status storage is separate from the main characters.
- R3: A RAM port write (`cmd_op`=5) loads `acc_in` into port number `bank_sel*4 + sel_addr[7:6]`. That port appears on `ram_port_out[4*n+3:4*n]`. `sel_addr[5:0]` is ignored.
- R4: A ROM port write (`cmd_op`=6) loads `acc_in` into ROM port `sel_addr[7:4]`. That port appears on `rom_port_out[4*n+3:4*n]`. `sel_addr[3:0]` and `bank_sel` are ignored.
- R5: A ROM port read (`cmd_op`=7) returns the latched value of port `sel_addr[7:4]` exactly as stored.
- R6: A port latch keeps its value until the next write to that same port. No other command and no write to another port alters it.
- R7: Read commands change no stored state. For commands that are not reads (0, 1, 3, 5, 6), `rd_data` is 0.
- R8: Synchronous active-high reset clears every RAM and ROM port latch to 0. Character and status contents survive reset.
- R9: The idle command (`cmd_op`=0) changes no stored state, whatever the other inputs carry.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset of the port latches |
| cmd_op | input | 3 | Command code (0 idle … 7 ROM port read, see requirements) |
| sel_addr | input | 8 | Previously loaded select value |
| bank_sel | input | 3 | Current RAM bank |
| stat_idx | input | 2 | Status character index |
| acc_in | input | 4 | Accumulator nibble to be written |
| rd_data | output | 4 | Read result, combinational |
| ram_port_out | output | 128 | 32 RAM port latches, 4 bits each, port n at bits 4n+3..4n |
| rom_port_out | output | 64 | 16 ROM port latches, 4 bits each, port n at bits 4n+3..4n |

## Verification
A wrong field split in the select decoder lands a write at the wrong location. It shows on `rd_data` when the intended location is read back, which in the stimulus is a few commands later. A misrouted port write is visible one cycle after the write, either as the wrong nibble changing on `ram_port_out` or `rom_port_out` or as the intended one staying put. Every port is compared against the reference on every command, so a latch disturbed by an unrelated command is caught within one cycle. A lost reset clear is visible on the first command after reset is released.

// File: rtl/bstore_pkg.sv
package bstore_pkg;

    localparam int NIB_W     = 4;
    localparam int BANKS     = 8;
    localparam int CHIPS     = 4;
    localparam int REGS      = 4;
    localparam int CHARS     = 16;
    localparam int STATS     = 4;
    localparam int ROMS      = 16;

    localparam int BANK_W    = $clog2(BANKS);
    localparam int CHIP_W    = $clog2(CHIPS);
    localparam int REG_W     = $clog2(REGS);
    localparam int CHAR_W    = $clog2(CHARS);
    localparam int STAT_W    = $clog2(STATS);
    localparam int ROM_W     = $clog2(ROMS);
    localparam int SEL_W     = CHIP_W + REG_W + CHAR_W;

    localparam int RAMPORTS  = BANKS * CHIPS;
    localparam int MAIN_D    = BANKS * CHIPS * REGS * CHARS;
    localparam int STAT_D    = BANKS * CHIPS * REGS * STATS;
    localparam int MAIN_AW   = $clog2(MAIN_D);
    localparam int STAT_AW   = $clog2(STAT_D);
    localparam int RAMP_AW   = $clog2(RAMPORTS);

    typedef enum logic [2:0] {
        OP_IDLE        = 3'd0,
        OP_PUT_CHAR    = 3'd1,
        OP_GET_CHAR    = 3'd2,
        OP_PUT_STAT    = 3'd3,
        OP_GET_STAT    = 3'd4,
        OP_PUT_RAMPORT = 3'd5,
        OP_PUT_ROMPORT = 3'd6,
        OP_GET_ROMPORT = 3'd7
    } op_e;

    typedef struct packed {
        logic [MAIN_AW-1:0] main_a;
        logic [STAT_AW-1:0] stat_a;
        logic [RAMP_AW-1:0] ramp_a;
        logic [ROM_W-1:0]   romp_a;
    } route_t;

    function automatic logic op_is_read(input op_e op);
        return (op == OP_GET_CHAR) || (op == OP_GET_STAT) ||
               (op == OP_GET_ROMPORT);
    endfunction

endpackage

// File: rtl/sel_route.sv
module sel_route
    import bstore_pkg::*;
(
    input  logic [SEL_W-1:0]  sel,
    input  logic [BANK_W-1:0] bank,
    input  logic [STAT_W-1:0] sidx,
    output route_t            rt
);
    localparam int CHIP_LO = REG_W + CHAR_W;
    localparam int REG_LO  = CHAR_W;

    logic [CHIP_W-1:0] chip_f;
    logic [REG_W-1:0]  reg_f;
    logic [CHAR_W-1:0] char_f;

    always_comb begin
        chip_f    = sel[SEL_W-1:CHIP_LO];
        reg_f     = sel[CHIP_LO-1:REG_LO];
        char_f    = sel[REG_LO-1:0];
        rt.main_a = {bank, chip_f, reg_f, char_f};
        rt.stat_a = {bank, chip_f, reg_f, sidx};
        rt.ramp_a = {bank, chip_f};
        rt.romp_a = sel[SEL_W-1:SEL_W-ROM_W];
    end
endmodule

// File: rtl/nib_array.sv
module nib_array #(
    parameter int DEPTH = 64,
    parameter int W     = 4,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] addr,
    input  logic [W-1:0]  wdata,
    output logic [W-1:0]  rdata
);
    logic [W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            mem[addr] <= wdata;
        end
    end

    assign rdata = mem[addr];
endmodule

// File: rtl/port_bank.sv
module port_bank #(
    parameter int COUNT = 16,
    parameter int W     = 4,
    localparam int AW   = $clog2(COUNT)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               we,
    input  logic [AW-1:0]      idx,
    input  logic [W-1:0]       wdata,
    output logic [COUNT*W-1:0] q_flat
);
    for (genvar g = 0; g < COUNT; g++) begin : g_latch
        logic [W-1:0] q;
        always_ff @(posedge clk) begin
            if (rst) begin
                q <= '0;
            end else if (we && (idx == AW'(g))) begin
                q <= wdata;
            end
        end
        assign q_flat[g*W +: W] = q;
    end
endmodule

// File: rtl/banked_store.sv
module banked_store
    import bstore_pkg::*;
(
    input  logic                      clk,
    input  logic                      rst,
    input  logic [2:0]                cmd_op,
    input  logic [SEL_W-1:0]          sel_addr,
    input  logic [BANK_W-1:0]         bank_sel,
    input  logic [STAT_W-1:0]         stat_idx,
    input  logic [NIB_W-1:0]          acc_in,
    output logic [NIB_W-1:0]          rd_data,
    output logic [RAMPORTS*NIB_W-1:0] ram_port_out,
    output logic [ROMS*NIB_W-1:0]     rom_port_out
);
    op_e            op;
    route_t         rt;
    logic [NIB_W-1:0] main_rd;
    logic [NIB_W-1:0] stat_rd;
    logic [NIB_W-1:0] rom_arr [ROMS];

    assign op = op_e'(cmd_op);

    sel_route u_route (
        .sel  (sel_addr),
        .bank (bank_sel),
        .sidx (stat_idx),
        .rt   (rt)
    );

    nib_array #(.DEPTH(MAIN_D), .W(NIB_W)) u_main (
        .clk   (clk),
        .we    (op == OP_PUT_CHAR),
        .addr  (rt.main_a),
        .wdata (acc_in),
        .rdata (main_rd)
    );

    nib_array #(.DEPTH(STAT_D), .W(NIB_W)) u_stat (
        .clk   (clk),
        .we    (op == OP_PUT_STAT),
        .addr  (rt.stat_a),
        .wdata (acc_in),
        .rdata (stat_rd)
    );

    port_bank #(.COUNT(RAMPORTS), .W(NIB_W)) u_ramports (
        .clk    (clk),
        .rst    (rst),
        .we     (op == OP_PUT_RAMPORT),
        .idx    (rt.ramp_a),
        .wdata  (acc_in),
        .q_flat (ram_port_out)
    );

    port_bank #(.COUNT(ROMS), .W(NIB_W)) u_romports (
        .clk    (clk),
        .rst    (rst),
        .we     (op == OP_PUT_ROMPORT),
        .idx    (rt.romp_a),
        .wdata  (acc_in),
        .q_flat (rom_port_out)
    );

    for (genvar g = 0; g < ROMS; g++) begin : g_rom_unpack
        assign rom_arr[g] = rom_port_out[g*NIB_W +: NIB_W];
    end

    always_comb begin
        rd_data = '0;
        if (op_is_read(op)) begin
            unique case (op)
                OP_GET_CHAR:    rd_data = main_rd;
                OP_GET_STAT:    rd_data = stat_rd;
                OP_GET_ROMPORT: rd_data = rom_arr[rt.romp_a];
                default:        rd_data = '0;
            endcase
        end
    end
endmodule

// File: rtl/banked_store_chk.sv
module banked_store_chk
    import bstore_pkg::*;
(
    input logic                      clk,
    input logic                      rst,
    input logic [2:0]                cmd_op,
    input logic [SEL_W-1:0]          sel_addr,
    input logic [BANK_W-1:0]         bank_sel,
    input logic [NIB_W-1:0]          acc_in,
    input logic [NIB_W-1:0]          rd_data,
    input logic [RAMPORTS*NIB_W-1:0] ram_port_out,
    input logic [ROMS*NIB_W-1:0]     rom_port_out
);
    logic [RAMP_AW-1:0] ramp_q;
    logic [ROM_W-1:0]   romp_q;
    logic [NIB_W-1:0]   acc_q;

    always_ff @(posedge clk) begin
        ramp_q <= {bank_sel, sel_addr[SEL_W-1 -: CHIP_W]};
        romp_q <= sel_addr[SEL_W-1 -: ROM_W];
        acc_q  <= acc_in;
    end

    assert_ramport_load_R3: assert property (@(posedge clk) disable iff (rst)
        (cmd_op == OP_PUT_RAMPORT) |=> (ram_port_out[ramp_q*NIB_W +: NIB_W] == acc_q));

    assert_romport_load_R4: assert property (@(posedge clk) disable iff (rst)
        (cmd_op == OP_PUT_ROMPORT) |=> (rom_port_out[romp_q*NIB_W +: NIB_W] == acc_q));

    assert_romport_read_R5: assert property (@(posedge clk) disable iff (rst)
        (cmd_op == OP_GET_ROMPORT) |->
            (rd_data == rom_port_out[sel_addr[SEL_W-1 -: ROM_W]*NIB_W +: NIB_W]));

    assert_ramport_hold_R6: assert property (@(posedge clk) disable iff (rst)
        (cmd_op != OP_PUT_RAMPORT) |=> $stable(ram_port_out));

    assert_romport_hold_R6: assert property (@(posedge clk) disable iff (rst)
        (cmd_op != OP_PUT_ROMPORT) |=> $stable(rom_port_out));

    assert_nonread_zero_R7: assert property (@(posedge clk) disable iff (rst)
        (cmd_op == OP_IDLE || cmd_op == OP_PUT_CHAR || cmd_op == OP_PUT_STAT ||
         cmd_op == OP_PUT_RAMPORT || cmd_op == OP_PUT_ROMPORT) |-> (rd_data == '0));

    assert_reset_clear_R8: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (ram_port_out == '0 && rom_port_out == '0));
endmodule

bind banked_store banked_store_chk u_chk (
    .clk          (clk),
    .rst          (rst),
    .cmd_op       (cmd_op),
    .sel_addr     (sel_addr),
    .bank_sel     (bank_sel),
    .acc_in       (acc_in),
    .rd_data      (rd_data),
    .ram_port_out (ram_port_out),
    .rom_port_out (rom_port_out)
);

// File: tb/banked_store_bench.sv
module banked_store_bench;
    import bstore_pkg::*;

    logic                      clk = 1'b0;
    logic                      rst = 1'b1;
    logic [2:0]                cmd_op = 3'd0;
    logic [7:0]                sel_addr = '0;
    logic [2:0]                bank_sel = '0;
    logic [1:0]                stat_idx = '0;
    logic [3:0]                acc_in = '0;
    logic [3:0]                rd_data;
    logic [127:0]              ram_port_out;
    logic [63:0]               rom_port_out;

    int vectors = 0;
    int misses  = 0;

    int ref_main [2048];
    bit ref_main_v [2048];
    int ref_stat [512];
    bit ref_stat_v [512];
    int ref_ram [32];
    int ref_rom [16];

    always #4 clk = ~clk;

    banked_store u_banked_store (
        .clk          (clk),
        .rst          (rst),
        .cmd_op       (cmd_op),
        .sel_addr     (sel_addr),
        .bank_sel     (bank_sel),
        .stat_idx     (stat_idx),
        .acc_in       (acc_in),
        .rd_data      (rd_data),
        .ram_port_out (ram_port_out),
        .rom_port_out (rom_port_out)
    );

    task automatic do_reset(input string req);
        @(negedge clk);
        rst = 1'b1;
        cmd_op = 3'd0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        for (int i = 0; i < 32; i++) ref_ram[i] = 0;
        for (int i = 0; i < 16; i++) ref_rom[i] = 0;
    endtask

    task automatic step(input int op, input int sel, input int bank,
                        input int sidx, input int acc, input string req);
        int  exp_rd;
        bit  known;
        int  mi, si, pi, ri;
        @(negedge clk);
        cmd_op = op[2:0]; sel_addr = sel[7:0]; bank_sel = bank[2:0];
        stat_idx = sidx[1:0]; acc_in = acc[3:0];
        #1;
        mi = bank * 256 + sel;
        si = bank * 64 + (sel / 16) * 4 + sidx;
        pi = bank * 4 + sel / 64;
        ri = sel / 16;
        known  = 1'b1;
        exp_rd = 0;
        case (op)
            2: begin known = ref_main_v[mi]; exp_rd = ref_main[mi]; end
            4: begin known = ref_stat_v[si]; exp_rd = ref_stat[si]; end
            7: exp_rd = ref_rom[ri];
            default: exp_rd = 0;
        endcase
        if (known) begin
            vectors++;
            if (rd_data !== exp_rd[3:0]) begin
                misses++;
                $display("FAIL %s rd_data op=%0d sel=%02h bank=%0d: got %0h expected %0h",
                         req, op, sel, bank, rd_data, exp_rd);
            end
        end
        vectors++;
        for (int p = 0; p < 32; p++) begin
            if (ram_port_out[p*4 +: 4] !== ref_ram[p][3:0]) begin
                misses++;
                $display("FAIL %s ram port %0d: got %0h expected %0h",
                         req, p, ram_port_out[p*4 +: 4], ref_ram[p]);
            end
        end
        for (int p = 0; p < 16; p++) begin
            if (rom_port_out[p*4 +: 4] !== ref_rom[p][3:0]) begin
                misses++;
                $display("FAIL %s rom port %0d: got %0h expected %0h",
                         req, p, rom_port_out[p*4 +: 4], ref_rom[p]);
            end
        end
        case (op)
            1: begin ref_main[mi] = acc; ref_main_v[mi] = 1'b1; end
            3: begin ref_stat[si] = acc; ref_stat_v[si] = 1'b1; end
            5: ref_ram[pi] = acc;
            6: ref_rom[ri] = acc;
            default: ;
        endcase
    endtask

    initial begin
        #(8 * 150000);
        misses++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
        $finish;
    end

    initial begin
        do_reset("R8");
        step(0, 8'hFF, 7, 3, 15, "R8");        // R8 ports cleared after reset

        // R1: characters across banks
        for (int b = 0; b < 8; b++) step(1, (b * 37 + 5) & 255, b, 0, b + 3, "R1");
        for (int b = 0; b < 8; b++) step(1, 8'h5A, b, 0, (b * 3 + 1) & 15, "R1");
        for (int b = 0; b < 8; b++) step(2, 8'h5A, b, 0, 0, "R1");
        for (int b = 0; b < 8; b++) step(2, (b * 37 + 5) & 255, b, 0, 0, "R1");
        step(1, 8'hC7, 5, 0, 4'hE, "R1");
        step(2, 8'hC7, 5, 0, 0, "R1");

        // R2: status characters, low select bits ignored, separate storage
        step(1, 8'h90, 2, 0, 4'h6, "R2");
        for (int k = 0; k < 4; k++) step(3, 8'h93, 2, k, 9 + k, "R2");
        for (int k = 0; k < 4; k++) step(4, 8'h9F, 2, k, 0, "R2");
        step(2, 8'h90, 2, 0, 0, "R2");
        step(3, 8'h90, 6, 1, 4'h3, "R2");
        step(4, 8'h90, 2, 1, 0, "R2");
        step(4, 8'h95, 6, 1, 0, "R2");

        // R3: every RAM port with varied ignored bits
        for (int p = 0; p < 32; p++)
            step(5, ((p % 4) << 6) | ((p * 7) & 63), p / 4, 0, (p * 5 + 2) & 15, "R3");
        step(0, 0, 0, 0, 0, "R3");

        // R6: rewrite one port, others hold through other commands
        step(5, 8'h80, 3, 0, 4'h0, "R6");
        step(1, 8'h80, 3, 0, 4'h7, "R6");
        step(3, 8'h80, 3, 0, 4'h7, "R6");
        step(6, 8'h80, 3, 0, 4'h7, "R6");

        // R4 / R5: ROM ports, bank and low bits ignored
        for (int r = 0; r < 16; r++)
            step(6, (r << 4) | ((r ^ 5) & 15), r % 8, 0, 15 - r, "R4");
        for (int r = 0; r < 16; r++)
            step(7, (r << 4) | 4'hA, (r + 3) % 8, 0, 0, "R5");

        // R7: reads leave state, non-read commands return zero
        step(2, 8'h5A, 4, 0, 4'hF, "R7");
        step(7, 8'h30, 0, 0, 4'hF, "R7");
        step(4, 8'h93, 2, 2, 4'hF, "R7");
        step(2, 8'h5A, 4, 0, 0, "R7");
        step(4, 8'h93, 2, 2, 0, "R7");
        step(5, 8'h40, 1, 0, 4'h9, "R7");

        // R9: idle with busy inputs
        step(0, 8'h5A, 4, 3, 4'hF, "R9");
        step(0, 8'h00, 0, 0, 4'h1, "R9");
        step(2, 8'h5A, 4, 0, 0, "R9");

        // R8: reset mid-run clears ports, memory survives
        do_reset("R8");
        step(0, 0, 0, 0, 0, "R8");
        step(2, 8'h5A, 3, 0, 0, "R8");
        step(4, 8'h9C, 2, 3, 0, "R8");
        step(7, 8'hF0, 0, 0, 0, "R8");

        $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
        $finish;
    end
endmodule